// File: doc/BRIEF.md
# Memory-Side Array Add Engine

This block sits next to a memory controller and carries out simple array work on behalf of a host. The host issues one command at a time over a valid/ready port. A register file of eight 32-bit entries holds operand base addresses and the element count. Three operations are supported. An immediate write puts a constant into a register. A load fetches one memory word into a register. An element-wise add reads two source arrays and writes their sums to a destination array.

The engine does not drive memory itself. It pushes read and write transactions into a transaction-queue port and receives read data on a response port. Each read carries a one-bit tag, and the tag tells the engine which operand latch the returned word belongs to. During an add, the write of one element's sum is queued immediately ahead of the two reads for the next element. This keeps the memory pipeline busy across element boundaries.

An add must stay inside one memory page of `PAGE_ELEMS` words. If any of its three ranges would cross a page boundary, the add is refused: the engine raises an error flag and issues no traffic.

Top module: `array_add_engine`

## Requirements
- R1: After synchronous reset, `cmd_ready` is 1 and `busy`, `err` and `tq_valid` are 0.
- R2: A command is taken when `cmd_valid` and `cmd_ready` are both high at a clock edge. A load or add raises `busy` from its acceptance until its final transaction has completed, and `cmd_ready` stays low during that time. An immediate write leaves `busy` low.
- R3: Opcode 2'b01 (immediate write) stores `cmd_val` into register `cmd_rd` and queues no transaction.
- R4: Opcode 2'b00 (load) queues exactly one read, with address `cmd_val` and tag 0. The returned word is stored in register `cmd_rd`.
- R5: Opcode 2'b10 (add) uses the registers `cmd_rs1`, `cmd_rs2` and `cmd_rd` as base addresses. For each element i it queues, in this order, a read of src1+i (tag 0), a read of src2+i (tag 1), and then a write to dst+i of the 32-bit wrapped sum of the two words.
- R6: Each write except the last is followed directly in the queue by the two reads for the next element. The last write ends the add.
- R7: The element count of an add is taken from register 7 when the add is accepted. Exactly that many writes are issued. A count of 0 issues no transaction and returns to ready.
- R8: If any of the three ranges [base, base+count-1] spans two pages of `PAGE_ELEMS` words, the add sets `err`, queues nothing, and returns to ready. `err` is cleared when the next command is accepted. A range that ends on the last word of a page runs normally.
- R9: Read data is routed to its operand by `rsp_tag` (0 goes to the first source, 1 to the second), whatever order the two responses arrive in.
- R10: While `tq_valid` is high and `tq_ready` is low, the pending transaction is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 2 | 00 load, 01 immediate write, 10 add, 11 no operation |
| cmd_rd | input | 3 | Destination register |
| cmd_rs1 | input | 3 | First source register (add) |
| cmd_rs2 | input | 3 | Second source register (add) |
| cmd_val | input | 32 | Load address or immediate value |
| tq_valid | output | 1 | Transaction offered to queue |
| tq_ready | input | 1 | Queue accepts transaction |
| tq_write | output | 1 | 1 write, 0 read |
| tq_tag | output | 1 | Read operand tag |
| tq_addr | output | 32 | Word address |
| tq_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data returned |
| rsp_tag | input | 1 | Tag of returned read |
| rsp_data | input | 32 | Returned word |
| busy | output | 1 | Load or add in progress |
| err | output | 1 | Last add refused for page crossing |

## Verification
The collision that matters happens when the first source word comes back while the read for the second source is still being pushed into the queue. In that cycle the engine must latch a response and advance a queue handshake at the same time. The bench memory returns data one cycle after each push, so every add runs into this case. Further runs add random queue stalls, which spread the overlap across several cycles, and delay only the tag-0 responses, so the tag-1 word arrives first. Each run is judged by the full ordered transaction log and by the sums found in memory afterwards.

// File: rtl/aae_pkg.sv
package aae_pkg;
  localparam logic [1:0] OP_LOAD = 2'b00;
  localparam logic [1:0] OP_LDI  = 2'b01;
  localparam logic [1:0] OP_ADD  = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_LDREQ, S_LDWAIT, S_CHK, S_RD1, S_RD2, S_WAIT, S_WR
  } state_t;
endpackage

// File: rtl/aae_regfile.sv
module aae_regfile #(
  parameter int DW       = 32,
  parameter int NREG     = 8,
  parameter int SIZE_IDX = 7,
  localparam int RW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] ra_a,
  input  logic [RW-1:0] ra_b,
  input  logic [RW-1:0] ra_c,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic [DW-1:0] rd_c,
  output logic [DW-1:0] rd_size
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rd_a    = regs[ra_a];
  assign rd_b    = regs[ra_b];
  assign rd_c    = regs[ra_c];
  assign rd_size = regs[SIZE_IDX];
endmodule

// File: rtl/aae_ctrl.sv
module aae_ctrl
  import aae_pkg::*;
#(
  parameter int DW         = 32,
  parameter int RW         = 3,
  parameter int PAGE_ELEMS = 1024,
  localparam int PGB       = $clog2(PAGE_ELEMS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [RW-1:0] cmd_rd,
  input  logic [DW-1:0] cmd_val,
  input  logic [DW-1:0] base1,
  input  logic [DW-1:0] base2,
  input  logic [DW-1:0] based,
  input  logic [DW-1:0] size,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          tq_valid,
  input  logic          tq_ready,
  output logic          tq_write,
  output logic          tq_tag,
  output logic [DW-1:0] tq_addr,
  output logic [DW-1:0] tq_wdata,
  input  logic          rsp_valid,
  input  logic          rsp_tag,
  input  logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          err
);
  state_t        state;
  logic [DW-1:0] ptr1, ptr2, ptrd, remain, op1, op2;
  logic          got1, got2, err_q;
  logic [RW-1:0] ld_reg;
  logic [1:0]    rd_cnt;

  function automatic logic spans(input logic [DW-1:0] base, input logic [DW-1:0] n);
    logic [DW:0] last;
    last = {1'b0, base} + {1'b0, n} - 1'b1;
    return (last >> PGB) != ({1'b0, base} >> PGB);
  endfunction

  wire accept  = cmd_valid && cmd_ready;
  wire tq_fire = tq_valid && tq_ready;
  wire in_add  = (state == S_RD1) || (state == S_RD2) || (state == S_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      err_q  <= 1'b0;
      got1   <= 1'b0;
      got2   <= 1'b0;
      rd_cnt <= 2'd0;
    end else begin
      if (rsp_valid && in_add) begin
        if (rsp_tag) begin op2 <= rsp_data; got2 <= 1'b1; end
        else         begin op1 <= rsp_data; got1 <= 1'b1; end
      end
      if (tq_fire && !tq_write && state != S_LDREQ) rd_cnt <= rd_cnt + 2'd1;
      unique case (state)
        S_IDLE: if (accept) begin
          err_q <= 1'b0;
          if (cmd_op == OP_LOAD) begin
            ptr1   <= cmd_val;
            ld_reg <= cmd_rd;
            state  <= S_LDREQ;
          end else if (cmd_op == OP_ADD) begin
            ptr1   <= base1;
            ptr2   <= base2;
            ptrd   <= based;
            remain <= size;
            state  <= S_CHK;
          end
        end
        S_LDREQ:  if (tq_ready) state <= S_LDWAIT;
        S_LDWAIT: if (rsp_valid) state <= S_IDLE;
        S_CHK: begin
          got1   <= 1'b0;
          got2   <= 1'b0;
          rd_cnt <= 2'd0;
          if (remain == '0) state <= S_IDLE;
          else if (spans(ptr1, remain) || spans(ptr2, remain) || spans(ptrd, remain)) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else state <= S_RD1;
        end
        S_RD1:  if (tq_ready) state <= S_RD2;
        S_RD2:  if (tq_ready) state <= S_WAIT;
        S_WAIT: if (got1 && got2) state <= S_WR;
        S_WR: if (tq_ready) begin
          got1   <= 1'b0;
          got2   <= 1'b0;
          rd_cnt <= 2'd0;
          ptr1   <= ptr1 + 1'b1;
          ptr2   <= ptr2 + 1'b1;
          ptrd   <= ptrd + 1'b1;
          remain <= remain - 1'b1;
          state  <= (remain == DW'(1)) ? S_IDLE : S_RD1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    tq_valid = 1'b0;
    tq_write = 1'b0;
    tq_tag   = 1'b0;
    tq_addr  = ptr1;
    tq_wdata = op1 + op2;
    unique case (state)
      S_LDREQ, S_RD1: tq_valid = 1'b1;
      S_RD2: begin tq_valid = 1'b1; tq_tag = 1'b1; tq_addr = ptr2; end
      S_WR:  begin tq_valid = 1'b1; tq_write = 1'b1; tq_addr = ptrd; end
      default: ;
    endcase
  end

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = cmd_rd;
    rf_wdata = cmd_val;
    if (state == S_IDLE && accept && cmd_op == OP_LDI) rf_we = 1'b1;
    else if (state == S_LDWAIT && rsp_valid) begin
      rf_we    = 1'b1;
      rf_waddr = ld_reg;
      rf_wdata = rsp_data;
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign err       = err_q;

  a_r3_ldi_quiet: assert property (@(posedge clk) disable iff (rst)
    accept && cmd_op == OP_LDI |=> !tq_valid);
  a_r5_second_read_tag: assert property (@(posedge clk) disable iff (rst)
    tq_valid && !tq_write && rd_cnt == 2'd1 |-> tq_tag);
  a_r6_write_after_pair: assert property (@(posedge clk) disable iff (rst)
    tq_valid && tq_write |-> rd_cnt == 2'd2);
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
    err |-> !tq_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    tq_valid && !tq_ready |=> tq_valid && $stable(tq_addr) && $stable(tq_write) && $stable(tq_tag));
endmodule

// File: rtl/array_add_engine.sv
module array_add_engine #(
  parameter int DW         = 32,
  parameter int NREG       = 8,
  parameter int SIZE_IDX   = 7,
  parameter int PAGE_ELEMS = 1024,
  localparam int RW        = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [RW-1:0] cmd_rd,
  input  logic [RW-1:0] cmd_rs1,
  input  logic [RW-1:0] cmd_rs2,
  input  logic [DW-1:0] cmd_val,
  output logic          tq_valid,
  input  logic          tq_ready,
  output logic          tq_write,
  output logic          tq_tag,
  output logic [DW-1:0] tq_addr,
  output logic [DW-1:0] tq_wdata,
  input  logic          rsp_valid,
  input  logic          rsp_tag,
  input  logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          err
);
  logic          rf_we;
  logic [RW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata, base1, base2, based, size;

  aae_regfile #(.DW(DW), .NREG(NREG), .SIZE_IDX(SIZE_IDX)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_a(cmd_rs1), .ra_b(cmd_rs2), .ra_c(cmd_rd),
    .rd_a(base1), .rd_b(base2), .rd_c(based), .rd_size(size)
  );

  aae_ctrl #(.DW(DW), .RW(RW), .PAGE_ELEMS(PAGE_ELEMS)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_rd(cmd_rd), .cmd_val(cmd_val),
    .base1(base1), .base2(base2), .based(based), .size(size),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .tq_valid(tq_valid), .tq_ready(tq_ready), .tq_write(tq_write),
    .tq_tag(tq_tag), .tq_addr(tq_addr), .tq_wdata(tq_wdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .busy(busy), .err(err)
  );
endmodule

// File: tb/test_array_add_engine.sv
module test_array_add_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [1:0]  cmd_op = 2'b11;
  logic [2:0]  cmd_rd = '0, cmd_rs1 = '0, cmd_rs2 = '0;
  logic [31:0] cmd_val = '0;
  logic        tq_valid, tq_ready = 1'b1, tq_write, tq_tag;
  logic [31:0] tq_addr, tq_wdata;
  logic        rsp_valid = 1'b0, rsp_tag = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        busy, err;

  array_add_engine i_array_add_engine (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [4096];
  int lg_n = 0;
  logic        lg_w [256];
  logic        lg_t [256];
  logic [31:0] lg_a [256], lg_d [256];
  int          p_n = 0, now = 0;
  logic        p_t [16];
  logic [31:0] p_d [16];
  int          p_due [16];
  bit          swap_mode = 0, stall_mode = 0;
  logic [7:0]  lfsr = 8'h5a;

  function automatic logic [31:0] ival(int a);
    return 32'(a) * 32'd13 + 32'd5;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mem_model;
    forever begin
      @(negedge clk);
      now++;
      rsp_valid = 1'b0;
      for (int k = 0; k < p_n; k++) begin
        if (p_due[k] <= now) begin
          rsp_valid = 1'b1; rsp_tag = p_t[k]; rsp_data = p_d[k];
          for (int j = k; j < p_n - 1; j++) begin
            p_t[j] = p_t[j+1]; p_d[j] = p_d[j+1]; p_due[j] = p_due[j+1];
          end
          p_n--;
          break;
        end
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tq_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
      if (tq_valid && tq_ready) begin
        if (lg_n < 256) begin
          lg_w[lg_n] = tq_write; lg_t[lg_n] = tq_tag;
          lg_a[lg_n] = tq_addr;  lg_d[lg_n] = tq_wdata;
          lg_n++;
        end
        if (tq_write) mem[tq_addr[11:0]] = tq_wdata;
        else begin
          p_t[p_n] = tq_tag; p_d[p_n] = mem[tq_addr[11:0]];
          p_due[p_n] = now + ((swap_mode && !tq_tag) ? 4 : 1);
          p_n++;
        end
      end
    end
  endtask

  task automatic send(logic [1:0] op, logic [2:0] rd, logic [2:0] r1, logic [2:0] r2, logic [31:0] v);
    cmd_op = op; cmd_rd = rd; cmd_rs1 = r1; cmd_rs2 = r2; cmd_val = v; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ldi(logic [2:0] r, logic [31:0] v);
    send(2'b01, r, 3'd0, 3'd0, v);
  endtask

  // Checks log and memory for an add of n elements starting at log entry 0
  task automatic check_add(int s1, int s2, int d, int n, string req);
    chk(lg_n == 3 * n, req, 32'(lg_n), 32'(3 * n));
    for (int i = 0; i < n && 3 * i + 2 < lg_n; i++) begin
      chk(!lg_w[3*i] && !lg_t[3*i] && lg_a[3*i] == 32'(s1 + i), {req, " rd1"}, lg_a[3*i], 32'(s1 + i));
      chk(!lg_w[3*i+1] && lg_t[3*i+1] && lg_a[3*i+1] == 32'(s2 + i), {req, " rd2"}, lg_a[3*i+1], 32'(s2 + i));
      chk(lg_w[3*i+2] && lg_a[3*i+2] == 32'(d + i), {req, " wr addr"}, lg_a[3*i+2], 32'(d + i));
      chk(lg_d[3*i+2] == ival(s1 + i) + ival(s2 + i), {req, " wr sum"}, lg_d[3*i+2], ival(s1 + i) + ival(s2 + i));
      chk(mem[12'(d + i)] == ival(s1 + i) + ival(s2 + i), {req, " mem"}, mem[12'(d + i)], ival(s1 + i) + ival(s2 + i));
    end
  endtask

  task automatic t_reset;
    chk(cmd_ready === 1'b1, "R1 ready", 32'(cmd_ready), 1);
    chk(busy === 1'b0 && err === 1'b0, "R1 busy/err", 32'({busy, err}), 0);
    chk(tq_valid === 1'b0, "R1 tq_valid", 32'(tq_valid), 0);
  endtask

  task automatic t_basic_add;
    ldi(3'd1, 100); ldi(3'd2, 200); ldi(3'd3, 300);
    lg_n = 0;
    ldi(3'd7, 3);
    chk(busy == 1'b0, "R2 ldi not busy", 32'(busy), 0);
    repeat (3) @(negedge clk);
    chk(lg_n == 0, "R3 ldi no traffic", 32'(lg_n), 0);
    send(2'b10, 3'd3, 3'd1, 3'd2, 0);
    chk(busy == 1'b1 && cmd_ready == 1'b0, "R2 busy on add", 32'({busy, cmd_ready}), 32'b10);
    wait_idle();
    check_add(100, 200, 300, 3, "R5 R6 R7 basic");
    chk(cmd_ready == 1'b1 && err == 1'b0, "R2 ready after add", 32'({cmd_ready, err}), 32'b10);
  endtask

  task automatic t_load;
    lg_n = 0;
    send(2'b00, 3'd4, 3'd0, 3'd0, 50);
    chk(busy == 1'b1, "R2 busy on load", 32'(busy), 1);
    wait_idle();
    chk(lg_n == 1 && !lg_w[0] && !lg_t[0] && lg_a[0] == 50, "R4 single read", lg_a[0], 50);
    ldi(3'd7, 1);
    lg_n = 0;
    send(2'b10, 3'd4, 3'd1, 3'd2, 0);
    wait_idle();
    check_add(100, 200, 32'(ival(50)), 1, "R4 loaded base");
  endtask

  task automatic t_size0;
    ldi(3'd7, 0);
    lg_n = 0;
    send(2'b10, 3'd3, 3'd1, 3'd2, 0);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(lg_n == 0 && err == 1'b0 && cmd_ready == 1'b1, "R7 zero count", 32'(lg_n), 0);
  endtask

  task automatic t_page;
    ldi(3'd1, 1020); ldi(3'd2, 3100); ldi(3'd3, 3000); ldi(3'd7, 5);
    lg_n = 0;
    send(2'b10, 3'd3, 3'd1, 3'd2, 0);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(lg_n == 0, "R8 crossing no traffic", 32'(lg_n), 0);
    chk(err == 1'b1 && cmd_ready == 1'b1, "R8 err set", 32'({err, cmd_ready}), 32'b11);
    ldi(3'd1, 1019);
    chk(err == 1'b0, "R8 err cleared", 32'(err), 0);
    lg_n = 0;
    send(2'b10, 3'd3, 3'd1, 3'd2, 0);
    wait_idle();
    chk(err == 1'b0, "R8 page-end ok", 32'(err), 0);
    check_add(1019, 3100, 3000, 5, "R8 page-end run");
  endtask

  task automatic t_swap;
    swap_mode = 1;
    ldi(3'd1, 400); ldi(3'd2, 500); ldi(3'd5, 800); ldi(3'd7, 3);
    lg_n = 0;
    send(2'b10, 3'd5, 3'd1, 3'd2, 0);
    wait_idle();
    check_add(400, 500, 800, 3, "R9 reversed return");
    swap_mode = 0;
  endtask

  task automatic t_stall;
    stall_mode = 1;
    ldi(3'd1, 2000); ldi(3'd2, 2100); ldi(3'd6, 2200); ldi(3'd7, 4);
    lg_n = 0;
    send(2'b10, 3'd6, 3'd1, 3'd2, 0);
    wait_idle();
    check_add(2000, 2100, 2200, 4, "R10 stalled queue");
    stall_mode = 0;
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = ival(a);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    fork mem_model(); join_none
    @(negedge clk);
    t_basic_add();
    t_load();
    t_size0();
    t_page();
    t_swap();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule